// File: doc/BRIEF.md
# Chip-to-Chip Interrupt Event Router

The router sits between a chip's event sources and a serial chip-to-chip link. It watches 64 event lines. Lines 0 to 31 come from a chip-level interrupt controller and lines 32 to 63 come from a queue-manager pend source. Each line has a per-vector routing entry. On a rising edge, the entry decides where the event goes. It either sets a bit in a local 32-bit status register or leaves the chip as an interrupt packet that carries the vector number. Packets that arrive from the far side are steered by the same table. They either set a local status bit or are forwarded as a single-cycle write to the system interrupt controller.

Outbound packets pass through an 8-entry queue and leave on a valid/ready port. The consumer may hold `out_ready` low for as long as it likes. While it does, `out_valid` and `out_vec` stay fixed, and events that find the queue full wait as pending bits inside the block. The inbound port has no ready signal: a packet presented with `in_valid` is always taken in that cycle. The status register is cleared by writing ones and drives a single combined interrupt. Serialization and the physical link belong to neighbouring blocks.

Top module: `irq_event_router`

## Requirements
- R1: After reset, `stat_q` is 0 and `irq_out`, `out_valid` and `fwd_valid` are low. Every routing entry defaults to local routing (local bit 1), status steering for received packets (steer bit 1), and status bit index equal to the vector number modulo 32.
- R2: An event acts only on a low-to-high transition of its input between two clock edges. A level held high produces exactly one action.
- R3: A rising event whose local bit is 1 sets `stat_q[idx]` at the same clock edge, where idx is the entry's 5-bit index. Several vectors may share one index.
- R4: A rising event whose local bit is 0 leaves `stat_q` untouched. Its vector appears on `out_vec` no earlier than two edges later. When several vectors wait at once, the lowest-numbered vector enters the queue first.
- R5: The outbound queue holds 8 vectors. Vectors that cannot enter it stay pending and are sent once space frees, so none is dropped. A new rising edge on a vector that is already pending is merged into that pending request.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_vec` stays unchanged. An entry is removed only on an edge where both are high.
- R7: An inbound packet (`in_valid` high) whose vector has steer bit 1 sets `stat_q[idx]` of that vector at the same edge.
- R8: An inbound packet whose vector has steer bit 0 leaves `stat_q` unchanged. After the next edge it produces a one-cycle `fwd_valid` pulse with `fwd_vec` equal to the vector.
- R9: Asserting `stat_clr_we` clears every status bit set in `stat_clr_mask`. A set and a clear of the same bit at the same edge leave the bit set.
- R10: `irq_out` is high exactly when at least one bit of `stat_q` is 1.
- R11: A routing-table write (`cfg_we`) takes effect from the following edge. An event or packet at the same edge as the write is routed by the old entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 64 | Event lines, rising-edge sensitive |
| cfg_we | input | 1 | Routing-table write strobe |
| cfg_vec | input | 6 | Vector whose entry is written |
| cfg_local | input | 1 | New local bit: 1 records locally, 0 sends a packet |
| cfg_stat | input | 1 | New steer bit: 1 sets status on receipt, 0 forwards |
| cfg_bit | input | 5 | New status bit index |
| in_valid | input | 1 | Inbound interrupt packet present (always accepted) |
| in_vec | input | 6 | Vector carried by the inbound packet |
| out_valid | output | 1 | Outbound packet available |
| out_ready | input | 1 | Link accepts the outbound packet |
| out_vec | output | 6 | Vector carried by the outbound packet |
| fwd_valid | output | 1 | One-cycle write to the system interrupt controller |
| fwd_vec | output | 6 | Vector of that write |
| stat_clr_we | input | 1 | Write-one-to-clear strobe for the status register |
| stat_clr_mask | input | 32 | Bits to clear |
| stat_q | output | 32 | Interrupt status register |
| irq_out | output | 1 | Combined interrupt, OR of all status bits |

## Verification
The bench fills the outbound queue while the consumer stalls and keeps raising events. A design that dropped events on a full queue, or that served pending vectors in some order other than lowest number first, would deliver a short or reordered packet stream. It re-raises a vector that is still pending. A design that queued the vector twice would send an extra packet. It collides a clear with a set of the same status bit. A design that let the clear win would lose an interrupt. It also rewrites a routing entry in the very cycle its event rises. A design with a bypass would send a packet where the old entry asked for a status bit. Long random runs with stalls, merged status bits and mixed inbound steering are compared against a behavioural model on every cycle.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int STAT_N = 32;
  localparam int IDX_W  = $clog2(STAT_N);

  typedef struct packed {
    logic             to_local;  // 1: record locally, 0: send packet
    logic             to_stat;   // received packet: 1 sets status, 0 forwards
    logic [IDX_W-1:0] bit_sel;   // status bit this vector drives
  } vec_cfg_t;
endpackage

// File: rtl/irq_cfg_table.sv
module irq_cfg_table
  import irq_router_pkg::*;
#(
  parameter int EVT_N = 64,
  localparam int VEC_W = $clog2(EVT_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_vec,
  input  vec_cfg_t         wr_cfg,
  output vec_cfg_t         cfg_q [EVT_N]
);
  for (genvar gi = 0; gi < EVT_N; gi++) begin : g_entry
    localparam vec_cfg_t RST_CFG = '{to_local: 1'b1, to_stat: 1'b1,
                                     bit_sel: IDX_W'(gi % STAT_N)};
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cfg_q[gi] <= RST_CFG;
      else if (wr_en && (wr_vec == VEC_W'(gi)))
        cfg_q[gi] <= wr_cfg;
    end
  end
endmodule

// File: rtl/irq_pend_arbiter.sv
module irq_pend_arbiter #(
  parameter int EVT_N = 64,
  localparam int VEC_W = $clog2(EVT_N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_N-1:0] req_set,
  input  logic             grant_en,
  output logic             grant_valid,
  output logic [VEC_W-1:0] grant_vec
);
  logic [EVT_N-1:0] pend_q;
  logic [EVT_N-1:0] take_mask;

  // lowest-numbered pending vector wins
  always_comb begin
    grant_vec = '0;
    for (int i = EVT_N - 1; i >= 0; i--)
      if (pend_q[i]) grant_vec = VEC_W'(i);
  end

  assign grant_valid = grant_en && (pend_q != '0);

  always_comb begin
    take_mask = '0;
    if (grant_valid) take_mask[grant_vec] = 1'b1;
  end

  // clear the served vector first, so a fresh edge on it re-arms the request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~take_mask) | req_set;
  end
endmodule

// File: rtl/irq_pkt_fifo.sv
module irq_pkt_fifo #(
  parameter int DEPTH = 8,          // power of two
  parameter int W     = 6,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         full,
  output logic         valid,
  output logic [W-1:0] data,
  output logic [PTR_W:0] count
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             do_pop;

  assign full   = (count == (PTR_W+1)'(DEPTH));
  assign valid  = (count != '0);
  assign data   = mem[rd_ptr];
  assign do_pop = pop && valid;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      count <= count + (PTR_W+1)'(push) - (PTR_W+1)'(do_pop);
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_mask,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] stat,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  // set applied after clear: a colliding set wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat <= '0;
    else        stat <= (stat & ~clr_eff) | set_mask;
  end

  assign irq = |stat;
endmodule

// File: rtl/irq_event_router.sv
module irq_event_router
  import irq_router_pkg::*;
#(
  parameter int EVT_N      = 64,
  parameter int FIFO_DEPTH = 8,
  localparam int VEC_W     = $clog2(EVT_N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  evt_in,
  input  logic              cfg_we,
  input  logic [VEC_W-1:0]  cfg_vec,
  input  logic              cfg_local,
  input  logic              cfg_stat,
  input  logic [IDX_W-1:0]  cfg_bit,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  in_vec,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VEC_W-1:0]  out_vec,
  output logic              fwd_valid,
  output logic [VEC_W-1:0]  fwd_vec,
  input  logic              stat_clr_we,
  input  logic [STAT_N-1:0] stat_clr_mask,
  output logic [STAT_N-1:0] stat_q,
  output logic              irq_out
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  vec_cfg_t          cfg [EVT_N];
  vec_cfg_t          wr_cfg;
  vec_cfg_t          in_cfg;
  logic [EVT_N-1:0]  evt_prev;
  logic [EVT_N-1:0]  rise;
  logic [EVT_N-1:0]  pend_set;
  logic [STAT_N-1:0] stat_set;
  logic              fifo_full;
  logic              grant_valid;
  logic [VEC_W-1:0]  grant_vec;
  logic [CNT_W-1:0]  fifo_cnt;

  assign wr_cfg = '{to_local: cfg_local, to_stat: cfg_stat, bit_sel: cfg_bit};

  irq_cfg_table #(.EVT_N(EVT_N)) u_cfg (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_we), .wr_vec(cfg_vec), .wr_cfg(wr_cfg),
    .cfg_q(cfg)
  );

  // rising-edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_prev <= '0;
    else        evt_prev <= evt_in;
  end
  assign rise   = evt_in & ~evt_prev;
  assign in_cfg = cfg[in_vec];

  always_comb begin
    stat_set = '0;
    pend_set = '0;
    for (int v = 0; v < EVT_N; v++) begin
      if (rise[v]) begin
        if (cfg[v].to_local) stat_set[cfg[v].bit_sel] = 1'b1;
        else                 pend_set[v] = 1'b1;
      end
    end
    if (in_valid && in_cfg.to_stat) stat_set[in_cfg.bit_sel] = 1'b1;
  end

  irq_pend_arbiter #(.EVT_N(EVT_N)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req_set(pend_set), .grant_en(!fifo_full),
    .grant_valid(grant_valid), .grant_vec(grant_vec)
  );

  irq_pkt_fifo #(.DEPTH(FIFO_DEPTH), .W(VEC_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(grant_valid), .push_data(grant_vec),
    .pop(out_ready), .full(fifo_full),
    .valid(out_valid), .data(out_vec), .count(fifo_cnt)
  );

  // forward path to the system interrupt controller
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_vec   <= '0;
    end else begin
      fwd_valid <= in_valid && !in_cfg.to_stat;
      fwd_vec   <= in_vec;
    end
  end

  irq_status_reg #(.N(STAT_N)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_mask(stat_set), .clr_we(stat_clr_we), .clr_mask(stat_clr_mask),
    .stat(stat_q), .irq(irq_out)
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int EVT_N  = 64,
  parameter int DEPTH  = 8,
  parameter int STAT_N = 32,
  localparam int VEC_W = $clog2(EVT_N),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [VEC_W-1:0]  out_vec,
  input logic              in_valid,
  input logic              fwd_valid,
  input logic              stat_clr_we,
  input logic [STAT_N-1:0] stat_clr_mask,
  input logic [STAT_N-1:0] stat_set,
  input logic [STAT_N-1:0] stat_q,
  input logic              irq_out,
  input logic [CNT_W-1:0]  fifo_cnt
);
  a_r6_hold_vec: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vec));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));

  a_r8_fwd_from_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(in_valid));

  a_r9_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_we |=> ((stat_q & $past(stat_clr_mask) & ~$past(stat_set)) == '0));

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_set != '0) |=> ((stat_q & $past(stat_set)) == $past(stat_set)));

  a_r10_irq_any: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (stat_q != '0));
endmodule

bind irq_event_router irq_router_chk #(
  .EVT_N(EVT_N), .DEPTH(FIFO_DEPTH), .STAT_N(irq_router_pkg::STAT_N)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
  .in_valid(in_valid), .fwd_valid(fwd_valid),
  .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask),
  .stat_set(stat_set), .stat_q(stat_q), .irq_out(irq_out),
  .fifo_cnt(fifo_cnt)
);

// File: tb/irq_event_router_tb.sv
`timescale 1ns/1ps
module irq_event_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] evt_in = '0;
  logic        cfg_we = 1'b0;
  logic [5:0]  cfg_vec = '0;
  logic        cfg_local = 1'b0;
  logic        cfg_stat = 1'b0;
  logic [4:0]  cfg_bit = '0;
  logic        in_valid = 1'b0;
  logic [5:0]  in_vec = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [5:0]  out_vec;
  logic        fwd_valid;
  logic [5:0]  fwd_vec;
  logic        stat_clr_we = 1'b0;
  logic [31:0] stat_clr_mask = '0;
  logic [31:0] stat_q;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_event_router u_dut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
    .cfg_we(cfg_we), .cfg_vec(cfg_vec), .cfg_local(cfg_local),
    .cfg_stat(cfg_stat), .cfg_bit(cfg_bit),
    .in_valid(in_valid), .in_vec(in_vec),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec),
    .fwd_valid(fwd_valid), .fwd_vec(fwd_vec),
    .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask),
    .stat_q(stat_q), .irq_out(irq_out)
  );

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_local [64];
  bit          m_tostat[64];
  int          m_idx   [64];
  bit [63:0]   m_prev, m_pend;
  bit [31:0]   m_stat;
  int          m_q[$];
  bit          m_fwd_v;
  int          m_fwd_vec;

  always @(posedge clk) begin : model
    bit [63:0] rise;
    bit [31:0] set;
    bit        do_push, do_pop;
    int        pv;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) begin
        m_local[i] = 1; m_tostat[i] = 1; m_idx[i] = i % 32;
      end
      m_prev = '0; m_pend = '0; m_stat = '0; m_q.delete();
      m_fwd_v = 0; m_fwd_vec = 0;
    end else begin
      rise    = evt_in & ~m_prev;
      do_pop  = (m_q.size() != 0) && out_ready;
      do_push = 0; pv = 0;
      for (int i = 63; i >= 0; i--)
        if (m_pend[i]) begin do_push = 1; pv = i; end
      if (m_q.size() >= 8) do_push = 0;
      if (do_push) m_pend[pv] = 0;
      set = '0;
      for (int i = 0; i < 64; i++)
        if (rise[i]) begin
          if (m_local[i]) set[m_idx[i]] = 1;
          else            m_pend[i] = 1;
        end
      if (in_valid && m_tostat[in_vec]) set[m_idx[in_vec]] = 1;
      m_fwd_v   = in_valid && !m_tostat[in_vec];
      m_fwd_vec = in_vec;
      if (stat_clr_we) m_stat &= ~stat_clr_mask;
      m_stat |= set;
      if (do_pop)  void'(m_q.pop_front());
      if (do_push) m_q.push_back(pv);
      if (cfg_we) begin
        m_local[cfg_vec] = cfg_local; m_tostat[cfg_vec] = cfg_stat;
        m_idx[cfg_vec] = cfg_bit;
      end
      m_prev = evt_in;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(stat_q == m_stat, "R3 stat_q vs model", stat_q, m_stat);
      chk(irq_out == (m_stat != 0), "R10 irq_out vs model", irq_out, m_stat != 0);
      chk(out_valid == (m_q.size() != 0), "R4 out_valid vs model", out_valid, m_q.size() != 0);
      if (m_q.size() != 0)
        chk(out_vec == m_q[0], "R4 out_vec vs model", out_vec, m_q[0]);
      chk(fwd_valid == m_fwd_v, "R8 fwd_valid vs model", fwd_valid, m_fwd_v);
      if (m_fwd_v)
        chk(fwd_vec == m_fwd_vec, "R8 fwd_vec vs model", fwd_vec, m_fwd_vec);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input int v, input bit loc, input bit st, input int b);
    cfg_we = 1; cfg_vec = 6'(v); cfg_local = loc; cfg_stat = st; cfg_bit = 5'(b);
    tick(1);
    cfg_we = 0;
  endtask

  task automatic clear_all();
    stat_clr_we = 1; stat_clr_mask = '1;
    tick(1);
    stat_clr_we = 0; stat_clr_mask = '0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin : stim
    int got[$];
    tick(4);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk(stat_q == 0, "R1 stat_q after reset", stat_q, 0);
    chk(irq_out == 0, "R1 irq_out after reset", irq_out, 0);
    chk(out_valid == 0, "R1 out_valid after reset", out_valid, 0);
    chk(fwd_valid == 0, "R1 fwd_valid after reset", fwd_valid, 0);

    // R3 local events set their default status bits
    evt_in[3:0] = 4'hF; tick(1); evt_in[3:0] = 0; tick(2);
    chk(stat_q == 32'hF, "R3 default local routing", stat_q, 32'hF);
    chk(irq_out == 1, "R10 irq with status set", irq_out, 1);
    clear_all();
    chk(stat_q == 0, "R9 write-one clear", stat_q, 0);

    // R2 a held level acts once
    evt_in[5] = 1; tick(3);
    stat_clr_we = 1; stat_clr_mask = 32'h20; tick(1);
    stat_clr_we = 0; stat_clr_mask = 0; tick(6);
    chk(stat_q[5] == 0, "R2 held level no re-trigger", stat_q[5], 0);
    evt_in[5] = 0; tick(1);

    // R3 two vectors sharing one status bit
    wr_cfg(40, 1, 1, 7); wr_cfg(41, 1, 1, 7);
    evt_in[41:40] = 2'b11; tick(1); evt_in[41:40] = 0; tick(2);
    chk(stat_q == 32'h80, "R3 shared status bit", stat_q, 32'h80);
    clear_all();

    // R4/R5/R6 remote routing with a stalled consumer
    for (int v = 10; v < 30; v++) wr_cfg(v, 0, 1, v % 32);
    evt_in[29:10] = '1; tick(1); evt_in[29:10] = 0; tick(2);
    evt_in[20] = 1; tick(1); evt_in[20] = 0;   // R5 merged into pending
    tick(20);
    chk(stat_q == 0, "R4 remote event leaves status alone", stat_q, 0);
    chk(out_valid == 1 && out_vec == 10, "R6 stalled head is lowest vector", out_vec, 10);
    out_ready = 1;
    for (int c = 0; c < 40; c++) begin
      if (out_valid) got.push_back(out_vec);
      tick(1);
    end
    out_ready = 0;
    chk(got.size() == 20, "R5 no loss and no duplicate", got.size(), 20);
    for (int k = 0; k < got.size() && k < 20; k++)
      chk(got[k] == 10 + k, "R4 lowest-first order", got[k], 10 + k);

    // R7 inbound packet steered to status
    in_valid = 1; in_vec = 3; tick(1); in_valid = 0; tick(1);
    chk(stat_q == 32'h8, "R7 inbound sets status", stat_q, 32'h8);
    // R9 clear and set colliding on bit 3
    stat_clr_we = 1; stat_clr_mask = 32'h8; in_valid = 1; in_vec = 3; tick(1);
    stat_clr_we = 0; stat_clr_mask = 0; in_valid = 0;
    chk(stat_q[3] == 1, "R9 set wins over clear", stat_q[3], 1);
    clear_all();

    // R8 inbound packet forwarded
    wr_cfg(50, 1, 0, 2);
    in_valid = 1; in_vec = 50; tick(1); in_valid = 0;
    chk(fwd_valid == 1 && fwd_vec == 50, "R8 forward pulse", fwd_vec, 50);
    chk(stat_q == 0, "R8 forward leaves status", stat_q, 0);
    tick(1);
    chk(fwd_valid == 0, "R8 pulse is one cycle", fwd_valid, 0);

    // R11 a write in the same cycle as the event uses the old entry
    cfg_we = 1; cfg_vec = 6; cfg_local = 0; cfg_stat = 1; cfg_bit = 6; evt_in[6] = 1;
    tick(1);
    cfg_we = 0; evt_in[6] = 0; tick(1);
    chk(stat_q == 32'h40 && !out_valid, "R11 old entry routes same-cycle event", stat_q, 32'h40);
    evt_in[6] = 1; tick(1); evt_in[6] = 0; tick(1);
    chk(out_valid && out_vec == 6, "R11 new entry applies next", out_vec, 6);
    out_ready = 1; tick(2); clear_all();

    // random phase: model compared every cycle (R6 stalls included)
    for (int c = 0; c < 4000; c++) begin
      evt_in = evt_in ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      out_ready = ($urandom % 4) != 0;
      in_valid = ($urandom % 3) == 0;
      in_vec = 6'($urandom);
      stat_clr_we = ($urandom % 5) == 0;
      stat_clr_mask = $urandom;
      cfg_we = ($urandom % 16) == 0;
      cfg_vec = 6'($urandom); cfg_local = 1'($urandom); cfg_stat = 1'($urandom);
      cfg_bit = 5'($urandom);
      tick(1);
    end
    cfg_we = 0; in_valid = 0; stat_clr_we = 0; out_ready = 1; evt_in = '0;
    tick(100);
    chk(out_valid == 0, "R5 backlog drains", out_valid, 0);
    finish_run();
  end
endmodule